// File: doc/BRIEF.md
# Ramp Conversion and Processing Sequencer

This block sequences an evaluator that digitises several inputs against a shared ramp and then runs a fixed number of coefficient accumulation steps. It walks through three phases: an idle phase, in which the shared data bus drives out the last result; a conversion phase, in which the internal counter sweeps as a ramp; and a processing phase, in which the same counter numbers the accumulation steps.

During conversion, each channel's comparator flag is turned into a single capture strobe. The channel's input register is meant to load the counter value on that strobe. A channel whose flag never rises is strobed on the last ramp value, so it captures full scale. Outside conversion every strobe is held inactive, so captured inputs cannot change while processing runs or while the result is shown. The counter restarts from zero on every phase change.

Top module: `ramp_seq`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, the block is idle: ep_o=1, proc_o=0, bus_oe_o=1, cnt_o=0, latch_en_o=0.
- R2: Status encoding is idle ep_o=1/proc_o=0, conversion ep_o=0/proc_o=0, processing ep_o=0/proc_o=1. ep_o and proc_o are never both high.
- R3: In idle, start_i sampled high at a clock edge moves the block to conversion at that edge, with cnt_o=0.
- R4: Conversion lasts exactly 2^CNT_W (256) cycles. cnt_o steps by one from 0 to 255 and then the block enters processing with cnt_o=0.
- R5: In conversion, latch_en_o[i] is high in the first cycle in which cmp_i[i] is high, combinationally, and for no other cycle of that sweep. The counter value in that cycle is the captured value.
- R6: A channel whose cmp_i bit stays low for the whole sweep gets its single strobe in the cycle with cnt_o=255.
- R7: latch_en_o is all zero in idle and in processing, whatever cmp_i does.
- R8: bus_oe_o is 1 (bus drives out the result) only in idle, and 0 in conversion and processing.
- R9: Processing lasts exactly STEPS (16) cycles with cnt_o counting 0 to 15. The block then returns to idle with cnt_o=0 and ep_o=1.
- R10: start_i has no effect in conversion or processing. Holding it high through a whole run changes neither phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only in idle |
| cmp_i | input | NUM_CH (3) | Per-channel comparator flags |
| ep_o | output | 1 | End-of-processing status, high in idle |
| proc_o | output | 1 | Processing status |
| bus_oe_o | output | 1 | Shared bus direction, 1 = drive result out |
| cnt_o | output | CNT_W (8) | Shared ramp / step counter |
| latch_en_o | output | NUM_CH (3) | Per-channel capture strobes |

## Verification
Status, bus direction and counter are registered, so they move one edge after the stimulus that causes them. start_i high at edge k shows conversion from edge k onward, processing begins 256 edges later, and idle returns 16 edges after that. latch_en_o is combinational from cmp_i and the registered state, so it is due in the same cycle as the flag. The driver sets the inputs just after a falling edge and queues the outputs it expects for that cycle, and the monitor compares them half a clock before the next rising edge. Per-run checks then compare captured values, strobe counts and phase lengths against the thresholds that were applied.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_PROC = 2'b10
  } seq_state_e;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import ramp_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int STEPS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output seq_state_e       state_o,
  output logic             enter_o
);
  localparam logic [CNT_W-1:0] RampTop  = '1;
  localparam logic [CNT_W-1:0] StepLast = CNT_W'(STEPS - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)             state_d = ST_CONV;
      ST_CONV: if (cnt_i == RampTop)    state_d = ST_PROC;
      ST_PROC: if (cnt_i == StepLast)   state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign enter_o = (state_d != state_q);
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/latch_gate.sv
module latch_gate #(
  parameter int NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              last_i,
  input  logic [NUM_CH-1:0] cmp_i,
  output logic [NUM_CH-1:0] strobe_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic fired_q;
    logic stb;

    // one strobe per sweep; last ramp value forces full scale
    assign stb = conv_i && !fired_q && (cmp_i[g] || last_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      fired_q <= 1'b0;
      else if (!conv_i) fired_q <= 1'b0;
      else if (stb)     fired_q <= 1'b1;
    end

    assign strobe_o[g] = stb;
  end
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
  import ramp_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 3,
  parameter int STEPS  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] cmp_i,
  output logic              ep_o,
  output logic              proc_o,
  output logic              bus_oe_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NUM_CH-1:0] latch_en_o
);
  localparam logic [CNT_W-1:0] RampTop = '1;

  seq_state_e       state;
  logic             enter;
  logic [CNT_W-1:0] cnt;
  logic             conv;

  seq_fsm #(.CNT_W(CNT_W), .STEPS(STEPS)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cnt_i   (cnt),
    .state_o (state),
    .enter_o (enter)
  );

  step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (enter),
    .en_i   (state != ST_IDLE),
    .cnt_o  (cnt)
  );

  assign conv = (state == ST_CONV);

  latch_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .conv_i   (conv),
    .last_i   (cnt == RampTop),
    .cmp_i    (cmp_i),
    .strobe_o (latch_en_o)
  );

  assign ep_o     = (state == ST_IDLE);
  assign proc_o   = (state == ST_PROC);
  assign bus_oe_o = (state == ST_IDLE);
  assign cnt_o    = cnt;
endmodule

// File: rtl/ramp_seq_chk.sv
module ramp_seq_chk #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 3,
  parameter int STEPS  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ep_o,
  input logic              proc_o,
  input logic              bus_oe_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [NUM_CH-1:0] latch_en_o
);
  localparam logic [CNT_W-1:0] StepLast = CNT_W'(STEPS - 1);

  a_r2_status_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ep_o && proc_o));

  a_r3_start_enters_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_o && start_i) |=> (!ep_o && !proc_o && cnt_o == '0));

  a_r4_ramp_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ep_o && !proc_o && cnt_o != '1) |=>
      (!ep_o && !proc_o && cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  a_r4_ramp_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ep_o && !proc_o && cnt_o == '1) |=> (proc_o && cnt_o == '0));

  a_r7_no_strobe_outside_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_o || proc_o) |-> (latch_en_o == '0));

  a_r8_bus_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == ep_o);

  a_r9_proc_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_o && cnt_o == StepLast) |=> (ep_o && cnt_o == '0));
endmodule

bind ramp_seq ramp_seq_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .STEPS(STEPS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ep_o       (ep_o),
  .proc_o     (proc_o),
  .bus_oe_o   (bus_oe_o),
  .cnt_o      (cnt_o),
  .latch_en_o (latch_en_o)
);

// File: tb/ramp_seq_test.sv
`timescale 1ns/1ps
module ramp_seq_test;
  localparam int CNT_W = 8;
  localparam int NCH   = 3;
  localparam int STEPS = 16;
  localparam int TOP   = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [NCH-1:0]   cmp_i = '0;
  logic             ep_o, proc_o, bus_oe_o;
  logic [CNT_W-1:0] cnt_o;
  logic [NCH-1:0]   latch_en_o;

  ramp_seq #(.CNT_W(CNT_W), .NUM_CH(NCH), .STEPS(STEPS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .ep_o(ep_o), .proc_o(proc_o), .bus_oe_o(bus_oe_o), .cnt_o(cnt_o),
    .latch_en_o(latch_en_o)
  );

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic           ep, proc, oe;
    int             cnt;
    logic [NCH-1:0] lat;
    int             ph;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // bench model: 0 idle, 1 conv, 2 proc
  int       m_ph = 0, m_cnt = 0;
  bit [NCH-1:0] m_fired = '0;

  int cap[NCH];
  int stb_n[NCH];
  int conv_cyc = 0, proc_cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_cnt = 0; m_fired = '0;
  endtask

  task automatic step(input logic st, input logic [NCH-1:0] cm);
    exp_t e;
    int nph;
    start_i = st;
    cmp_i   = cm;
    #0.5;
    e.ep  = (m_ph == 0);
    e.proc = (m_ph == 2);
    e.oe  = (m_ph == 0);
    e.cnt = m_cnt;
    e.ph  = m_ph;
    for (int i = 0; i < NCH; i++)
      e.lat[i] = (m_ph == 1) && !m_fired[i] && (cm[i] || m_cnt == TOP);
    exp_q.push_back(e);
    -> mon_ev;
    @(posedge clk_i);
    nph = m_ph;
    if (m_ph == 0 && st) nph = 1;
    else if (m_ph == 1 && m_cnt == TOP) nph = 2;
    else if (m_ph == 2 && m_cnt == STEPS - 1) nph = 0;
    if (m_ph == 1) m_fired = m_fired | e.lat; else m_fired = '0;
    if (nph != m_ph) m_cnt = 0; else if (m_ph != 0) m_cnt++;
    m_ph = nph;
    @(negedge clk_i);
  endtask

  // monitor: pops one expected item per driven cycle
  initial forever begin
    exp_t e;
    @(mon_ev);
    e = exp_q.pop_front();
    chk(ep_o == e.ep && proc_o == e.proc, "R2", "status {ep,proc}",
        {ep_o, proc_o}, {e.ep, e.proc});
    chk(bus_oe_o == e.oe, "R8", "bus_oe_o", bus_oe_o, e.oe);
    if (e.ph == 2) chk(int'(cnt_o) == e.cnt, "R9", "step count", cnt_o, e.cnt);
    else           chk(int'(cnt_o) == e.cnt, "R4", "ramp count", cnt_o, e.cnt);
    if (e.ph == 1) chk(latch_en_o == e.lat, "R5", "latch_en_o", latch_en_o, e.lat);
    else           chk(latch_en_o == e.lat, "R7", "latch_en_o held", latch_en_o, e.lat);
    if (!ep_o && !proc_o) conv_cyc++;
    if (proc_o) proc_cyc++;
    for (int i = 0; i < NCH; i++)
      if (latch_en_o[i]) begin cap[i] = cnt_o; stb_n[i]++; end
  end

  task automatic run(input int t0, input int t1, input int t2, input bit hold);
    int thr[NCH];
    thr[0] = t0; thr[1] = t1; thr[2] = t2;
    for (int i = 0; i < NCH; i++) begin cap[i] = -1; stb_n[i] = 0; end
    conv_cyc = 0; proc_cyc = 0;
    for (int k = 0; k < 2 + TOP + 1 + STEPS + 1; k++) begin
      logic [NCH-1:0] cm;
      logic st;
      for (int i = 0; i < NCH; i++)
        cm[i] = (m_ph == 1) ? (m_cnt >= thr[i]) : 1'b1;
      st = hold ? (k <= TOP + 1 + STEPS) : (k == 0);
      step(st, cm);
    end
    chk(conv_cyc == TOP + 1, "R4", "conversion length", conv_cyc, TOP + 1);
    chk(proc_cyc == STEPS, "R9", "processing length", proc_cyc, STEPS);
    for (int i = 0; i < NCH; i++) begin
      int ev = (thr[i] > TOP) ? TOP : thr[i];
      chk(stb_n[i] == 1, "R5", "strobes per sweep", stb_n[i], 1);
      if (thr[i] > TOP) chk(cap[i] == ev, "R6", "full-scale capture", cap[i], ev);
      else              chk(cap[i] == ev, "R5", "captured value", cap[i], ev);
    end
    if (hold) chk(ep_o == 1'b1, "R10", "idle after held start", ep_o, 1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    #1;
    // R1: state during reset, with start high
    start_i = 1'b1; cmp_i = '1;
    #6;
    chk(ep_o && !proc_o && bus_oe_o && cnt_o == 0 && latch_en_o == 0,
        "R1", "reset outputs", {ep_o, proc_o, bus_oe_o}, 3'b101);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 3'b111);
    step(1'b0, 3'b000);
    // R3: start from idle
    run(10, 200, 300, 1'b0);
    // R10: start held high through conversion and processing
    run(0, TOP, 128, 1'b1);
    run(300, 300, 1, 1'b0);
    // R1: asynchronous reset mid-conversion
    step(1'b1, 3'b000);
    for (int k = 0; k < 20; k++) step(1'b0, 3'b000);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(ep_o && !proc_o && cnt_o == 0, "R1", "reset mid-run", {ep_o, proc_o}, 2'b10);
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 3'b111);
    step(1'b0, 3'b111);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule